// File: doc/BRIEF.md
# Vector Element Load Alignment Unit

This unit carries out indexed loads into a 128-bit vector register. It takes one 32-bit instruction word and two 64-bit general register operands. From these it works out whether to fetch a single byte element, a halfword element or a whole 16-byte quadword. It adds the operands to form the effective address and issues one read for the aligned 16-byte line that holds the element. When the line comes back, it moves the wanted bytes into the byte lanes of the result that the chosen byte order calls for.

Lane selection uses the low four bits of the effective address. In big-endian mode that value is the lane number. In little-endian mode the lane is mirrored to 15 minus that value. Lanes that an element load does not fill read as zero. Instructions that do not decode are flagged and cause no memory traffic.

Top module: `vlane_load`

## Requirements
- R1: An instruction decodes when its top six bits `insn[31:26]` equal 31. The function field `insn[10:1]` selects the load: 7 is a byte element, 39 is a halfword element and 103 is a full quadword. The target number is `insn[25:21]`, the base field is `insn[20:16]` and the index field is `insn[15:11]`.
- R2: The effective address is the index operand plus the base operand. The base operand counts as zero when the base field is 0. For halfword loads, address bit 0 is cleared.
- R3: `memReqAddr` is the effective address with its low four bits cleared. `memReqValid` rises the cycle after the instruction is accepted. It stays high with a stable address until a cycle in which `memReqReady` is high.
- R4: An instruction is accepted only in a cycle where both `inValid` and `inReady` are high. `inReady` is low from acceptance until `resValid` is raised, and `inValid` has no effect while `inReady` is low.
- R5: Byte k of the returned line (address line+k) arrives on `memRspData[8k+7:8k]`. Result lane j is `resData[127-8j:120-8j]`.
- R6: A big-endian byte load puts line byte eb into lane eb, where eb is the low four address bits. All other lanes are zero.
- R7: A little-endian byte load puts line byte eb into lane 15-eb. All other lanes are zero.
- R8: A halfword load puts line bytes eb and eb+1 into lanes eb and eb+1 in big-endian mode, or into lanes 15-eb and 14-eb in little-endian mode. All other lanes are zero.
- R9: A quadword load puts line byte k into lane k in big-endian mode, or into lane 15-k in little-endian mode, for every k.
- R10: `resValid` is a one-cycle pulse, raised in the cycle after the one where `memRspValid` is seen while a read is outstanding. `resTarget` carries the target number at the same time.
- R11: An accepted instruction that does not decode raises `illegal` for exactly the next cycle. It issues no request and leaves `inReady` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction offered |
| inReady | output | 1 | Unit idle, instruction can be taken |
| insn | input | 32 | Instruction word |
| baseOp | input | 64 | Base register operand |
| idxOp | input | 64 | Index register operand |
| littleEndian | input | 1 | Little-endian lane placement when high |
| memReqValid | output | 1 | Line read request |
| memReqReady | input | 1 | Memory takes the request |
| memReqAddr | output | 64 | 16-byte-aligned line address |
| memRspValid | input | 1 | Line data returned |
| memRspData | input | 128 | Returned line, byte k at bits 8k+7:8k |
| resValid | output | 1 | Result pulse |
| resTarget | output | 5 | Target register number of the result |
| resData | output | 128 | Steered vector result |
| illegal | output | 1 | Undecodable instruction pulse |

## Verification
Counting from the acceptance edge, the request is due one cycle later. The `illegal` pulse is also due one cycle after acceptance. The result is due one cycle after the edge at which the response is taken. Each task drives inputs on the falling edge, steps over exactly one rising edge per stage, and samples on the next falling edge. Each stage is checked at the first edge where its output is allowed to change. A stall cycle with `memReqReady` low shows that the request is held. In that same cycle, a bad instruction offered on `inValid` shows that input is ignored while the unit is busy. One extra cycle after each pulse confirms the pulse lasts a single cycle.

// File: rtl/vlane_pkg.sv
package vlane_pkg;
  localparam logic [5:0] OPC_PRIMARY = 6'd31;
  localparam logic [9:0] XO_BYTE = 10'd7;
  localparam logic [9:0] XO_HALF = 10'd39;
  localparam logic [9:0] XO_QUAD = 10'd103;

  typedef enum logic [1:0] {
    KIND_BYTE,
    KIND_HALF,
    KIND_QUAD,
    KIND_BAD
  } elemKind_t;

  typedef struct packed {
    logic load;
    logic capture;
  } dpCtl_t;
endpackage

// File: rtl/vlane_ctrl.sv
module vlane_ctrl
  import vlane_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   kindIsBad,
  input  logic   memReqReady,
  input  logic   memRspValid,
  output logic   inReady,
  output logic   memReqValid,
  output logic   resValid,
  output logic   illegal,
  output dpCtl_t ctl
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} state_t;

  state_t state, stateNext;
  logic accept;

  assign inReady     = (state == ST_IDLE);
  assign memReqValid = (state == ST_REQ);
  assign accept      = inReady && inValid;

  always_comb begin
    ctl.load    = accept && !kindIsBad;
    ctl.capture = (state == ST_WAIT) && memRspValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (ctl.load) stateNext = ST_REQ;
      ST_REQ:  if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT: if (memRspValid) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      resValid <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      state    <= stateNext;
      resValid <= ctl.capture;
      illegal  <= accept && kindIsBad;
    end
  end
endmodule

// File: rtl/vlane_dp.sv
module vlane_dp
  import vlane_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int VEC_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtl_t                 ctl,
  input  logic [31:0]            insn,
  input  logic [ADDR_W-1:0]      baseOp,
  input  logic [ADDR_W-1:0]      idxOp,
  input  logic                   littleEndian,
  input  logic [VEC_BYTES*8-1:0] memRspData,
  output logic                   kindIsBad,
  output logic [ADDR_W-1:0]      memReqAddr,
  output logic [4:0]             resTarget,
  output logic [VEC_BYTES*8-1:0] resData
);
  localparam int OFF_W  = $clog2(VEC_BYTES);
  localparam int VEC_W  = VEC_BYTES * 8;

  elemKind_t kind, kindQ;
  logic [ADDR_W-1:0] baseEff, eaSum, eaAligned, eaQ;
  logic leQ;
  logic [OFF_W-1:0] eb;
  logic [VEC_W-1:0] steered;

  // decode
  always_comb begin
    kind = KIND_BAD;
    if (insn[31:26] == OPC_PRIMARY) begin
      unique case (insn[10:1])
        XO_BYTE: kind = KIND_BYTE;
        XO_HALF: kind = KIND_HALF;
        XO_QUAD: kind = KIND_QUAD;
        default: kind = KIND_BAD;
      endcase
    end
  end
  assign kindIsBad = (kind == KIND_BAD);

  // effective address
  assign baseEff   = (insn[20:16] == 5'd0) ? '0 : baseOp;
  assign eaSum     = baseEff + idxOp;
  assign eaAligned = eaSum & ~ADDR_W'(kind == KIND_HALF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ       <= '0;
      kindQ     <= KIND_BYTE;
      leQ       <= 1'b0;
      resTarget <= '0;
    end else if (ctl.load) begin
      eaQ       <= eaAligned;
      kindQ     <= kind;
      leQ       <= littleEndian;
      resTarget <= insn[25:21];
    end
  end

  assign memReqAddr = {eaQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign eb         = eaQ[OFF_W-1:0];

  // lane steering: lane j takes line byte j (BE) or VEC_BYTES-1-j (LE)
  for (genvar lane = 0; lane < VEC_BYTES; lane++) begin : gLane
    localparam logic [OFF_W-1:0] SRC_BE = OFF_W'(lane);
    localparam logic [OFF_W-1:0] SRC_LE = OFF_W'(VEC_BYTES - 1 - lane);
    logic [OFF_W-1:0] src;
    logic keep;
    assign src  = leQ ? SRC_LE : SRC_BE;
    assign keep = (kindQ == KIND_QUAD) || (src == eb) ||
                  ((kindQ == KIND_HALF) && (src == (eb | OFF_W'(1))));
    assign steered[VEC_W-1-8*lane -: 8] = keep ? memRspData[8*src +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resData <= '0;
    else if (ctl.capture) resData <= steered;
  end
endmodule

// File: rtl/vlane_load.sv
module vlane_load
  import vlane_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int VEC_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [31:0]            insn,
  input  logic [ADDR_W-1:0]      baseOp,
  input  logic [ADDR_W-1:0]      idxOp,
  input  logic                   littleEndian,
  output logic                   memReqValid,
  input  logic                   memReqReady,
  output logic [ADDR_W-1:0]      memReqAddr,
  input  logic                   memRspValid,
  input  logic [VEC_BYTES*8-1:0] memRspData,
  output logic                   resValid,
  output logic [4:0]             resTarget,
  output logic [VEC_BYTES*8-1:0] resData,
  output logic                   illegal
);
  dpCtl_t ctl;
  logic kindIsBad;

  vlane_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .kindIsBad(kindIsBad),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .inReady(inReady), .memReqValid(memReqValid), .resValid(resValid),
    .illegal(illegal), .ctl(ctl)
  );

  vlane_dp #(.ADDR_W(ADDR_W), .VEC_BYTES(VEC_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .insn(insn), .baseOp(baseOp),
    .idxOp(idxOp), .littleEndian(littleEndian), .memRspData(memRspData),
    .kindIsBad(kindIsBad), .memReqAddr(memReqAddr), .resTarget(resTarget),
    .resData(resData)
  );
endmodule

// File: rtl/vlane_load_chk.sv
module vlane_load_chk #(
  parameter int ADDR_W    = 64,
  parameter int VEC_BYTES = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic                   inReady,
  input logic                   memReqValid,
  input logic                   memReqReady,
  input logic [ADDR_W-1:0]      memReqAddr,
  input logic                   memRspValid,
  input logic                   resValid,
  input logic                   illegal
);
  localparam int OFF_W = $clog2(VEC_BYTES);

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[OFF_W-1:0] == '0); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr)); // R3
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !inReady); // R4
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid); // R10
  AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> inReady); // R4
  AST_ILL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    illegal |=> !illegal || $past(inValid)); // R11
  AST_ILL_NOREQ: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !memReqValid && inReady); // R11
endmodule

bind vlane_load vlane_load_chk #(.ADDR_W(ADDR_W), .VEC_BYTES(VEC_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
  .memRspValid(memRspValid), .resValid(resValid), .illegal(illegal)
);

// File: tb/sim_vlane_load.sv
`timescale 1ns/1ps
module sim_vlane_load;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inReady;
  logic [31:0] insn = '0;
  logic [63:0] baseOp = '0, idxOp = '0;
  logic littleEndian = 1'b0;
  logic memReqValid, memReqReady = 1'b0;
  logic [63:0] memReqAddr;
  logic memRspValid = 1'b0;
  logic [127:0] memRspData = '0;
  logic resValid, illegal;
  logic [4:0] resTarget;
  logic [127:0] resData;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vlane_load u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkInsn(input logic [5:0] opc, input logic [9:0] xo,
                                         input logic [4:0] vrt, input logic [4:0] ra);
    return {opc, vrt, ra, 5'd9, xo, 1'b0};
  endfunction

  function automatic logic [7:0] memByte(input logic [63:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hC3;
  endfunction

  function automatic logic [127:0] lineOf(input logic [63:0] lineAddr);
    logic [127:0] d;
    for (int k = 0; k < 16; k++) d[8*k +: 8] = memByte(lineAddr + 64'(k));
    return d;
  endfunction

  function automatic logic [127:0] putLane(input logic [127:0] v, input int lane,
                                           input logic [7:0] b);
    logic [127:0] r = v;
    r[127-8*lane -: 8] = b;
    return r;
  endfunction

  // kind: 0 byte, 1 halfword, 2 quadword
  task automatic doLoad(input int kind, input logic [4:0] ra, input logic [63:0] base,
                        input logic [63:0] idx, input bit le, input logic [4:0] vrt,
                        input string tag);
    logic [9:0] xo;
    logic [63:0] ea, line;
    logic [127:0] data, exp;
    int eb;
    xo = (kind == 0) ? 10'd7 : (kind == 1) ? 10'd39 : 10'd103;
    ea = ((ra == 0) ? 64'd0 : base) + idx;
    if (kind == 1) ea[0] = 1'b0;
    line = {ea[63:4], 4'h0};
    eb = int'(ea[3:0]);
    data = lineOf(line);
    exp = '0;
    if (kind == 2) begin
      for (int k = 0; k < 16; k++) exp = putLane(exp, le ? 15 - k : k, data[8*k +: 8]);
    end else begin
      exp = putLane(exp, le ? 15 - eb : eb, data[8*eb +: 8]);
      if (kind == 1) exp = putLane(exp, le ? 14 - eb : eb + 1, data[8*(eb+1) +: 8]);
    end

    @(negedge clk);
    insn = mkInsn(6'd31, xo, vrt, ra); baseOp = base; idxOp = idx;
    littleEndian = le; inValid = 1'b1;
    @(posedge clk); @(negedge clk);
    insn = mkInsn(6'd31, 10'd8, 5'd1, 5'd1); // bad word offered while busy
    chk(memReqValid === 1'b1, {tag, " R3 request raised"}, 128'(memReqValid), 128'd1);
    chk(memReqAddr === line, {tag, " R2 R3 line address"}, 128'(memReqAddr), 128'(line));
    chk(inReady === 1'b0, {tag, " R4 busy"}, 128'(inReady), 128'd0);
    @(posedge clk); @(negedge clk);
    chk(memReqValid === 1'b1 && memReqAddr === line, {tag, " R3 request held"},
        128'(memReqAddr), 128'(line));
    chk(illegal === 1'b0, {tag, " R4 input ignored while busy"}, 128'(illegal), 128'd0);
    memReqReady = 1'b1;
    @(posedge clk); @(negedge clk);
    memReqReady = 1'b0; inValid = 1'b0;
    chk(memReqValid === 1'b0, {tag, " R3 request dropped"}, 128'(memReqValid), 128'd0);
    memRspValid = 1'b1; memRspData = data;
    @(posedge clk); @(negedge clk);
    memRspValid = 1'b0; memRspData = '0;
    chk(resValid === 1'b1, {tag, " R10 result pulse"}, 128'(resValid), 128'd1);
    chk(resTarget === vrt, {tag, " R1 R10 target"}, 128'(resTarget), 128'(vrt));
    chk(resData === exp, {tag, " lanes"}, resData, exp);
    chk(inReady === 1'b1, {tag, " R4 ready again"}, 128'(inReady), 128'd1);
    @(posedge clk); @(negedge clk);
    chk(resValid === 1'b0, {tag, " R10 single pulse"}, 128'(resValid), 128'd0);
  endtask

  task automatic doIllegal(input logic [5:0] opc, input logic [9:0] xo, input string tag);
    @(negedge clk);
    insn = mkInsn(opc, xo, 5'd4, 5'd2); inValid = 1'b1;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    chk(illegal === 1'b1, {tag, " R11 flag"}, 128'(illegal), 128'd1);
    chk(memReqValid === 1'b0, {tag, " R11 no request"}, 128'(memReqValid), 128'd0);
    chk(inReady === 1'b1, {tag, " R11 stays ready"}, 128'(inReady), 128'd1);
    @(posedge clk); @(negedge clk);
    chk(illegal === 1'b0, {tag, " R11 single pulse"}, 128'(illegal), 128'd0);
    chk(memReqValid === 1'b0, {tag, " R11 still no request"}, 128'(memReqValid), 128'd0);
  endtask

  task automatic resetTest();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk(inReady === 1'b1, "reset R4 ready", 128'(inReady), 128'd1);
    chk(memReqValid === 1'b0, "reset R3 no request", 128'(memReqValid), 128'd0);
    chk(resValid === 1'b0, "reset R10 no result", 128'(resValid), 128'd0);
    chk(illegal === 1'b0, "reset R11 no flag", 128'(illegal), 128'd0);
    chk(resData === '0, "reset R5 result zero", resData, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    resetTest();
    doLoad(0, 5'd3, 64'h1000, 64'h25, 1'b0, 5'd7, "R6 byte big-endian");
    doLoad(0, 5'd0, 64'hDEAD, 64'h203B, 1'b1, 5'd12, "R7 R2 byte little-endian base zero");
    doLoad(1, 5'd5, 64'h40, 64'h7, 1'b0, 5'd2, "R8 R2 halfword big-endian odd sum");
    doLoad(1, 5'd0, 64'h1, 64'h3F, 1'b1, 5'd30, "R8 halfword little-endian lane 14");
    doLoad(2, 5'd8, 64'hFFFF_0000_0000_1000, 64'h237, 1'b0, 5'd31, "R9 R5 quadword big-endian");
    doLoad(2, 5'd8, 64'h8000, 64'h8D, 1'b1, 5'd0, "R9 quadword little-endian");
    doIllegal(6'd31, 10'd8, "bad function field");
    doIllegal(6'd30, 10'd7, "R1 bad primary field");
    doLoad(0, 5'd1, 64'h0, 64'hF, 1'b0, 5'd1, "R6 byte big-endian lane 15");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule